// File: doc/BRIEF.md
# Fault Escalation and Lockup Controller

This block watches the fault events of a small processor core and decides, cycle by cycle, what each one leads to. A fault taken in thread mode or in an ordinary handler becomes a request for the single fixed-priority hard-fault exception. A fault taken while the hard-fault or NMI handler is running cannot be escalated any further. The core then stops in a lockup state, and only a debugger halt, a reset or, in one case, an NMI releases it.

The block also turns the 32-bit exception-return word that the core loads into a program-counter slot into a target mode and a stack selection. Unknown words are flagged as reserved. The core's execute logic uses the registered outputs directly: it gates instruction issue with the execute enable and starts the hard-fault entry from the one-cycle request.

Top module: `fault_lockup_ctrl`

## Requirements
- R1: After reset is released, `hf_req_o`, `lockup_o`, `lock_origin_hf_o`, `ret_valid_o`, `ret_handler_o`, `ret_psp_o` and `ret_invalid_o` are 0 and `exec_en_o` is 1.
- R2: A fault seen while `ctx_i` is 00 (thread) or 01 (ordinary handler) sets `hf_req_o` to 1 for exactly the one cycle after the capturing edge, without lockup. Any bit of `fault_vec_i` counts as a fault, and several fault sources in one cycle give a single pulse.
- R3: A fault seen while `ctx_i` is 10 (hard-fault handler) or 11 (NMI handler) sets `lockup_o` on the next edge and gives no `hf_req_o`. In that case `lock_origin_hf_o` is 1 exactly when `ctx_i` was 10.
- R4: `unstack_bus_err_i` together with `unstack_main_i` = 1 enters lockup in any context. With `unstack_main_i` = 0 it is an ordinary fault handled as in R2 and R3.
- R5: `svc_exec_i` is a fault when `exec_pri_i` <= `svc_pri_i`, where a smaller number means a more urgent priority. Otherwise it has no effect.
- R6: `bkpt_i` is a fault when `dbg_attached_i` = 0 and has no effect when `dbg_attached_i` = 1.
- R7: `exec_en_o` is 0 in every cycle in which `lockup_o` is 1, and 1 otherwise.
- R8: `dbg_halt_i` during lockup clears `lockup_o` on the next edge, whatever the lockup origin.
- R9: `nmi_req_i` during lockup clears `lockup_o` only when `lock_origin_hf_o` is 1. When the lockup began in the NMI handler, it has no effect.
- R10: While locked up, fault inputs are ignored: `hf_req_o` stays 0 and `lockup_o` stays 1.
- R11: One cycle after `exc_ret_valid_i`, `ret_valid_o` is 1 and the decode of `exc_ret_val_i` is shown. 0xFFFFFFF1 gives handler=1 and psp=0. 0xFFFFFFF9 gives handler=0 and psp=0. 0xFFFFFFFD gives handler=0 and psp=1. Any other value gives invalid=1 with handler=0 and psp=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctx_i | input | 2 | Current context: 00 thread, 01 handler, 10 hard-fault handler, 11 NMI handler |
| fault_vec_i | input | NUM_FAULTS | Single-cycle fault strobes (bus error, undefined, bad state, unaligned, no-execute fetch, vector fetch, fetch fault) |
| svc_exec_i | input | 1 | Supervisor call executed this cycle |
| exec_pri_i | input | PRI_W | Current execution priority |
| svc_pri_i | input | PRI_W | Supervisor-call exception priority |
| bkpt_i | input | 1 | Breakpoint instruction executed |
| dbg_attached_i | input | 1 | Debugger is attached |
| unstack_bus_err_i | input | 1 | Bus error while unstacking the status word |
| unstack_main_i | input | 1 | The unstacking return uses the main stack |
| dbg_halt_i | input | 1 | Debugger halt request |
| nmi_req_i | input | 1 | NMI request |
| exc_ret_valid_i | input | 1 | Exception-return word present |
| exc_ret_val_i | input | 32 | Exception-return word |
| hf_req_o | output | 1 | One-cycle hard-fault request |
| lockup_o | output | 1 | Core is locked up |
| exec_en_o | output | 1 | Instruction execution enable |
| lock_origin_hf_o | output | 1 | Lockup began in the hard-fault handler |
| ret_valid_o | output | 1 | Decode outputs valid |
| ret_handler_o | output | 1 | Return to handler mode |
| ret_psp_o | output | 1 | Return on the process stack |
| ret_invalid_o | output | 1 | Reserved return word |

## Verification
Each result is registered once, so `hf_req_o`, `lockup_o`, the lockup origin and the return decode all change on the first edge after the stimulus. `exec_en_o` follows `lockup_o` in the same cycle. The bench changes inputs on falling edges, and it samples a few nanoseconds after the edge that captures them. It samples again after the following edge to confirm that the hard-fault pulse has ended, or that lockup has held or cleared as the requirement states. Release checks are made in the cycle after the release input, with the inputs driven back to idle.

// File: rtl/fault_pkg.sv
`timescale 1ns/1ps
package fault_pkg;
  typedef enum logic [1:0] {
    CTX_THREAD    = 2'b00,
    CTX_HANDLER   = 2'b01,
    CTX_HARDFAULT = 2'b10,
    CTX_NMI       = 2'b11
  } ctx_e;

  localparam int unsigned RET_W = 32;
  localparam logic [RET_W-1:0] RET_HANDLER_MSP = 32'hFFFF_FFF1;
  localparam logic [RET_W-1:0] RET_THREAD_MSP  = 32'hFFFF_FFF9;
  localparam logic [RET_W-1:0] RET_THREAD_PSP  = 32'hFFFF_FFFD;

  typedef struct packed {
    logic handler;
    logic psp;
    logic invalid;
  } ret_dec_t;
endpackage

// File: rtl/fault_collector.sv
`timescale 1ns/1ps
module fault_collector #(
  parameter int unsigned NUM_FAULTS = 7,
  parameter int unsigned PRI_W      = 2
) (
  input  logic [NUM_FAULTS-1:0] fault_vec_i,
  input  logic                  svc_exec_i,
  input  logic [PRI_W-1:0]      exec_pri_i,
  input  logic [PRI_W-1:0]      svc_pri_i,
  input  logic                  bkpt_i,
  input  logic                  dbg_attached_i,
  input  logic                  unstack_bus_err_i,
  input  logic                  unstack_main_i,
  output logic                  fault_any_o,
  output logic                  unstack_lock_o
);
  localparam int unsigned NUM_SRC = NUM_FAULTS + 3;

  logic [NUM_SRC-1:0] src;

  // Smaller priority number is more urgent.
  assign src[NUM_FAULTS]   = svc_exec_i & (exec_pri_i <= svc_pri_i);
  assign src[NUM_FAULTS+1] = bkpt_i & ~dbg_attached_i;
  assign src[NUM_FAULTS+2] = unstack_bus_err_i & ~unstack_main_i;

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_src
    assign src[g] = fault_vec_i[g];
  end

  assign fault_any_o    = |src;
  assign unstack_lock_o = unstack_bus_err_i & unstack_main_i;
endmodule

// File: rtl/lockup_fsm.sv
`timescale 1ns/1ps
module lockup_fsm
  import fault_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ctx_i,
  input  logic       fault_any_i,
  input  logic       unstack_lock_i,
  input  logic       dbg_halt_i,
  input  logic       nmi_req_i,
  output logic       hf_req_o,
  output logic       lockup_o,
  output logic       origin_hf_o
);
  logic lock_q, origin_q, hf_q;
  logic in_crit, lock_enter, hf_set, lock_exit;

  assign in_crit    = (ctx_i == CTX_HARDFAULT) | (ctx_i == CTX_NMI);
  assign lock_enter = ~lock_q & (unstack_lock_i | (fault_any_i & in_crit));
  assign hf_set     = ~lock_q & fault_any_i & ~lock_enter;
  assign lock_exit  = lock_q & (dbg_halt_i | (nmi_req_i & origin_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= 1'b0;
      origin_q <= 1'b0;
      hf_q     <= 1'b0;
    end else begin
      hf_q <= hf_set;
      if (lock_enter) begin
        lock_q   <= 1'b1;
        origin_q <= (ctx_i == CTX_HARDFAULT);
      end else if (lock_exit) begin
        lock_q   <= 1'b0;
        origin_q <= 1'b0;
      end
    end
  end

  assign hf_req_o    = hf_q;
  assign lockup_o    = lock_q;
  assign origin_hf_o = origin_q;

  assert_hf_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && fault_any_i && !in_crit && !unstack_lock_i) |=> (hf_q && !lock_q));
  assert_hf_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hf_q && !fault_any_i) |=> !hf_q);
  assert_crit_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && fault_any_i && in_crit) |=> (lock_q && !hf_q));
  assert_unstack_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && unstack_lock_i) |=> lock_q);
  assert_halt_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && dbg_halt_i) |=> !lock_q);
  assert_nmi_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !origin_q && !dbg_halt_i) |=> (lock_q && $stable(origin_q)));
  assert_no_hf_locked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> !hf_q);
endmodule

// File: rtl/exc_ret_decoder.sv
`timescale 1ns/1ps
module exc_ret_decoder
  import fault_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RET_W-1:0] value_i,
  output logic             valid_o,
  output ret_dec_t         dec_o
);
  ret_dec_t dec_d, dec_q;
  logic     valid_q;

  always_comb begin
    dec_d = '0;
    unique case (value_i)
      RET_HANDLER_MSP: dec_d.handler = 1'b1;
      RET_THREAD_MSP:  ;
      RET_THREAD_PSP:  dec_d.psp = 1'b1;
      default:         dec_d.invalid = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dec_q   <= '0;
    end else begin
      valid_q <= valid_i;
      dec_q   <= valid_i ? dec_d : '0;
    end
  end

  assign valid_o = valid_q;
  assign dec_o   = dec_q;

  assert_dec_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dec_q.handler, dec_q.psp, dec_q.invalid}));
  assert_dec_follow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && value_i[31:4] != 28'hFFFF_FFF) |=> (valid_q && dec_q.invalid));
  assert_dec_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (dec_q == '0));
endmodule

// File: rtl/fault_lockup_ctrl.sv
`timescale 1ns/1ps
module fault_lockup_ctrl
  import fault_pkg::*;
#(
  parameter int unsigned NUM_FAULTS = 7,
  parameter int unsigned PRI_W      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            ctx_i,
  input  logic [NUM_FAULTS-1:0] fault_vec_i,
  input  logic                  svc_exec_i,
  input  logic [PRI_W-1:0]      exec_pri_i,
  input  logic [PRI_W-1:0]      svc_pri_i,
  input  logic                  bkpt_i,
  input  logic                  dbg_attached_i,
  input  logic                  unstack_bus_err_i,
  input  logic                  unstack_main_i,
  input  logic                  dbg_halt_i,
  input  logic                  nmi_req_i,
  input  logic                  exc_ret_valid_i,
  input  logic [31:0]           exc_ret_val_i,
  output logic                  hf_req_o,
  output logic                  lockup_o,
  output logic                  exec_en_o,
  output logic                  lock_origin_hf_o,
  output logic                  ret_valid_o,
  output logic                  ret_handler_o,
  output logic                  ret_psp_o,
  output logic                  ret_invalid_o
);
  logic     fault_any, unstack_lock;
  ret_dec_t dec;

  fault_collector #(.NUM_FAULTS(NUM_FAULTS), .PRI_W(PRI_W)) u_collect (
    .fault_vec_i       (fault_vec_i),
    .svc_exec_i        (svc_exec_i),
    .exec_pri_i        (exec_pri_i),
    .svc_pri_i         (svc_pri_i),
    .bkpt_i            (bkpt_i),
    .dbg_attached_i    (dbg_attached_i),
    .unstack_bus_err_i (unstack_bus_err_i),
    .unstack_main_i    (unstack_main_i),
    .fault_any_o       (fault_any),
    .unstack_lock_o    (unstack_lock)
  );

  lockup_fsm u_lock (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctx_i          (ctx_i),
    .fault_any_i    (fault_any),
    .unstack_lock_i (unstack_lock),
    .dbg_halt_i     (dbg_halt_i),
    .nmi_req_i      (nmi_req_i),
    .hf_req_o       (hf_req_o),
    .lockup_o       (lockup_o),
    .origin_hf_o    (lock_origin_hf_o)
  );

  exc_ret_decoder u_ret (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (exc_ret_valid_i),
    .value_i (exc_ret_val_i),
    .valid_o (ret_valid_o),
    .dec_o   (dec)
  );

  assign exec_en_o     = ~lockup_o;
  assign ret_handler_o = dec.handler;
  assign ret_psp_o     = dec.psp;
  assign ret_invalid_o = dec.invalid;

  assert_svc_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lockup_o && svc_exec_i && (exec_pri_i > svc_pri_i) && fault_vec_i == '0 && !bkpt_i
     && !unstack_bus_err_i) |=> !hf_req_o && !lockup_o);
  assert_bkpt_dbg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lockup_o && bkpt_i && dbg_attached_i && fault_vec_i == '0 && !svc_exec_i
     && !unstack_bus_err_i) |=> !hf_req_o && !lockup_o);
endmodule

// File: tb/fault_lockup_ctrl_tb.sv
`timescale 1ns/1ps
module fault_lockup_ctrl_tb_top;
  localparam int NF = 7;
  localparam int PW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ctx;
  logic [NF-1:0] fvec;
  logic svc, bkpt, dbg_att, ub_err, ub_main, halt, nmi, rv;
  logic [PW-1:0] epri, spri;
  logic [31:0] rval;
  logic hf, lk, en, org, r_v, r_h, r_p, r_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_lockup_ctrl #(.NUM_FAULTS(NF), .PRI_W(PW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctx_i(ctx), .fault_vec_i(fvec),
    .svc_exec_i(svc), .exec_pri_i(epri), .svc_pri_i(spri), .bkpt_i(bkpt),
    .dbg_attached_i(dbg_att), .unstack_bus_err_i(ub_err), .unstack_main_i(ub_main),
    .dbg_halt_i(halt), .nmi_req_i(nmi), .exc_ret_valid_i(rv), .exc_ret_val_i(rval),
    .hf_req_o(hf), .lockup_o(lk), .exec_en_o(en), .lock_origin_hf_o(org),
    .ret_valid_o(r_v), .ret_handler_o(r_h), .ret_psp_o(r_p), .ret_invalid_o(r_i));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    fvec = '0; svc = 0; bkpt = 0; ub_err = 0; ub_main = 0;
    halt = 0; nmi = 0; rv = 0; rval = '0;
  endtask

  // Inputs already set after a falling edge: pass one rising edge, sample.
  task automatic edge_sample();
    @(posedge clk); #3;
  endtask

  task automatic next_cycle();
    @(negedge clk); idle();
  endtask

  // Fault state check with R7 coupling.
  task automatic chk_state(input string req, input logic e_hf, input logic e_lk);
    chk(req, {31'd0, hf}, {31'd0, e_hf});
    chk(req, {31'd0, lk}, {31'd0, e_lk});
    chk("R7", {31'd0, en}, {31'd0, ~e_lk});
  endtask

  task automatic release_by_halt();
    @(negedge clk); idle(); halt = 1; edge_sample();
    chk_state("R8", 1'b0, 1'b0);
    next_cycle();
  endtask

  initial begin
    ctx = 2'b00; epri = '0; spri = '0; dbg_att = 0; idle();
    repeat (2) @(negedge clk);
    rst_n = 1;
    edge_sample();
    chk_state("R1", 0, 0);
    chk("R1", {28'd0, org, r_v, r_h, r_p}, 32'd0);
    chk("R1", {31'd0, r_i}, 32'd0);

    // R2/R3: every fault bit in every context
    for (int c = 0; c < 4; c++) begin
      for (int b = 0; b < NF; b++) begin
        @(negedge clk); idle(); ctx = c[1:0]; fvec[b] = 1'b1;
        edge_sample();
        if (c < 2) chk_state("R2", 1, 0);
        else begin
          chk_state("R3", 0, 1);
          chk("R3", {31'd0, org}, {31'd0, c == 2});
        end
        next_cycle(); edge_sample();
        chk_state(c < 2 ? "R2" : "R10", 0, c >= 2);
        if (c >= 2) begin
          // NMI release only for hard-fault origin
          @(negedge clk); idle(); nmi = 1; edge_sample();
          chk_state("R9", 0, c == 3);
          next_cycle();
          if (c == 3) release_by_halt();
        end
      end
    end

    // R2: all sources at once, single pulse
    @(negedge clk); idle(); ctx = 2'b01; fvec = '1; svc = 1; bkpt = 1; ub_err = 1;
    edge_sample(); chk_state("R2", 1, 0);
    next_cycle(); edge_sample(); chk_state("R2", 0, 0);

    // R5: supervisor-call priority sweep
    for (int e = 0; e < 4; e++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); idle(); ctx = 2'b00; svc = 1; epri = e[1:0]; spri = s[1:0];
        edge_sample(); chk_state("R5", e <= s, 0);
        next_cycle(); edge_sample();
      end
    end

    // R6: breakpoint with and without debugger
    for (int d = 0; d < 2; d++) begin
      @(negedge clk); idle(); ctx = 2'b00; bkpt = 1; dbg_att = d[0];
      edge_sample(); chk_state("R6", d == 0, 0);
      next_cycle(); edge_sample();
    end
    dbg_att = 0;

    // R4: unstacking bus error, stack select x context
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 2; m++) begin
        @(negedge clk); idle(); ctx = c[1:0]; ub_err = 1; ub_main = m[0];
        edge_sample();
        chk_state("R4", (m == 0) && (c < 2), (m == 1) || (c >= 2));
        if ((m == 1) || (c >= 2)) chk("R4", {31'd0, org}, {31'd0, c == 2});
        next_cycle(); edge_sample();
        if ((m == 1) || (c >= 2)) release_by_halt();
      end
    end

    // R10: faults while locked are ignored
    @(negedge clk); idle(); ctx = 2'b11; fvec[0] = 1; edge_sample(); chk_state("R3", 0, 1);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); idle(); ctx = c[1:0]; fvec = '1; svc = 1; bkpt = 1; ub_err = 1;
      edge_sample(); chk_state("R10", 0, 1);
      chk("R10", {31'd0, org}, 32'd0);
    end
    next_cycle(); edge_sample(); chk_state("R10", 0, 1);
    ctx = 2'b00;
    release_by_halt();

    // R11: return-word decode
    for (int k = 0; k < 20; k++) begin
      logic [31:0] w;
      logic eh, ep, ei;
      if (k < 16) w = 32'hFFFF_FFF0 | k;
      else if (k == 16) w = 32'h7FFF_FFF9;
      else if (k == 17) w = 32'hFFFF_FFE9;
      else if (k == 18) w = 32'h0000_0001;
      else w = 32'hFFFF_FFFF;
      eh = (w == 32'hFFFF_FFF1);
      ep = (w == 32'hFFFF_FFFD);
      ei = !(eh || ep || w == 32'hFFFF_FFF9);
      @(negedge clk); idle(); rv = 1; rval = w;
      edge_sample();
      chk("R11", {28'd0, r_v, r_h, r_p, r_i}, {28'd0, 1'b1, eh, ep, ei});
    end
    next_cycle(); edge_sample();
    chk("R11", {28'd0, r_v, r_h, r_p, r_i}, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule